// File: doc/BRIEF.md
# Mixed-Length Fused Instruction Decoder

This front-end unit takes a stream of 32-bit aligned fetch words from a dense instruction set in which every instruction is either 16 or 32 bits long. It finds where each instruction starts. It extracts the opcode, register and immediate fields according to the instruction's format. It also reads the fuse bit that each instruction carries. An instruction with its fuse bit set is joined with the instruction that follows it, and the two leave the decoder together as one fused pair, so that a later scheduler can treat them as a single slot.

Fetch words arrive over a valid/ready handshake. A word flag marks the last word before a taken-branch boundary. A 32-bit instruction that begins in the upper halfword of a word is kept in a one-halfword buffer until the next word completes it. The decoder pulls at most one instruction out of its input window per cycle. A fused head is held back until its tail has been decoded. A registered output slot then presents either a single decoded instruction or a head/tail pair, also over valid/ready.

Top module: `mixlen_fuse_decoder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0. Reset also discards any buffered halfword and any held fused head.
- R2: Within a fetch word, the halfword in bits [15:0] comes before the one in bits [31:16]. An instruction's first halfword holds its upper 16 bits. Bit 15 of that first halfword is the fuse bit. Bit 14 is the length bit: 1 means a 32-bit instruction, 0 means a 16-bit one.
- R3: A 32-bit instruction `i` is classified by i[29:28]:
  - 00 is branch/call, format 0, with opcode i[30:21] and immediate = sign-extended i[20:0].
  - 01 is register-immediate, format 1, with rd i[20:16], rs1 i[15:11] and immediate = sign-extended i[10:0].
  - 10 is a long-immediate half with rd i[20:16]. When i[21] = 0 it is format 2 (low half), immediate = zero-extended i[15:0]. When i[21] = 1 it is format 3 (high half), immediate = i[15:0] shifted left by 16.
  - 11 is three-register, format 4, with opcode i[30:15], rd i[14:10], rs1 i[9:5], rs2 i[4:0] and immediate 0.
  - Formats 0 to 3 use i[30:21] as the opcode.
- R4: A 16-bit instruction `h` has opcode h[14:8] and is classified by h[13:12]:
  - 00 is format 5, with rd h[7:4] and rs1 h[3:0].
  - 01 is format 6, with rd h[7:4] and immediate = zero-extended h[3:0].
  - 10 or 11 is format 7, with immediate = sign-extended h[7:0].
- R5: A decoded slot is 67 bits wide, laid out as follows:
  - [66] is 1 for a 32-bit instruction.
  - [65:63] is the format.
  - [62:47] is the opcode, zero-extended.
  - [46:42] is rd, [41:37] is rs1 and [36:32] is rs2.
  - [31:0] is the immediate.
  - Any field a format does not use is 0.
- R6: A 32-bit instruction that starts in the upper halfword of a word is completed by the lower halfword of the next word and decoded as one instruction.
- R7: An instruction whose fuse bit is set is not emitted alone. It is emitted together with the next instruction as one output, with `out_pair` = 1, the head in `out_head` and the tail in `out_tail`.
- R8: The fuse bit of a tail is ignored. A pair never has more than two members, and the instruction after a pair is decoded on its own terms.
- R9: In a word flagged `in_last`, the final instruction has its fuse bit ignored and is emitted alone. The final instruction is the one that ends the word, or the one before an upper-halfword 32-bit start. A 32-bit instruction that starts in the upper halfword of such a word is discarded.
- R10: While `out_valid`=1 and `out_ready`=0, the output holds steady and no fetch word is accepted (`in_ready`=0).
- R11: When `out_pair` is 0, `out_tail` is all zeros.
- R12: While the output slot is free or draining, one instruction is extracted per cycle and appears on the output on the next cycle. `in_ready` is 1 only together with `in_valid`, in the cycle in which the last halfword of the word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Fetch word fully consumed this cycle |
| in_word | input | 32 | Fetch word, earlier halfword in [15:0] |
| in_last | input | 1 | Word ends at a taken-branch boundary |
| out_valid | output | 1 | Decoded output present |
| out_ready | input | 1 | Consumer accepts the output |
| out_pair | output | 1 | Output is a fused head/tail pair |
| out_head | output | 67 | Single instruction or pair head, slot layout of R5 |
| out_tail | output | 67 | Pair tail, zero when not a pair |

## Verification
The bench goes after boundary finding across words. A 32-bit instruction is split over two words, and a design that mis-tracked the halfword offset would emit garbled fields and then lose sync for every instruction after it. It builds pairs in three ways: a 16-bit head with a straddling 32-bit tail, two 32-bit long-immediate halves, and a tail that itself carries a fuse bit. A decoder that chained fuse bits would swallow the following instruction into a triple. Words marked as the last before a branch check that a trailing fuse bit does not leave a head stranded forever, and that a dangling 32-bit start is dropped rather than glued onto the next block. Backpressure windows and a reset that arrives while a head is held check that no output changes under stall and that no stale head is paired with the first instruction after reset.

// File: rtl/mixlen_fuse_decoder.sv
module mixlen_fuse_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_pair,
  output logic [66:0] out_head,
  output logic [66:0] out_tail
);

  function automatic logic [66:0] decode(input logic [31:0] i, input logic wide);
    logic [2:0]  fm;
    logic [15:0] op;
    logic [4:0]  rd, ra, rb;
    logic [31:0] im;
    fm = 3'd0; op = '0; rd = '0; ra = '0; rb = '0; im = '0;
    if (wide) begin
      op = {6'd0, i[30:21]};
      case (i[29:28])
        2'b00: begin
          fm = 3'd0;
          im = {{11{i[20]}}, i[20:0]};
        end
        2'b01: begin
          fm = 3'd1;
          rd = i[20:16];
          ra = i[15:11];
          im = {{21{i[10]}}, i[10:0]};
        end
        2'b10: begin
          rd = i[20:16];
          if (i[21]) begin
            fm = 3'd3;
            im = {i[15:0], 16'd0};
          end else begin
            fm = 3'd2;
            im = {16'd0, i[15:0]};
          end
        end
        default: begin
          fm = 3'd4;
          op = i[30:15];
          rd = i[14:10];
          ra = i[9:5];
          rb = i[4:0];
        end
      endcase
    end else begin
      op = {9'd0, i[14:8]};
      case (i[13:12])
        2'b00: begin
          fm = 3'd5;
          rd = {1'b0, i[7:4]};
          ra = {1'b0, i[3:0]};
        end
        2'b01: begin
          fm = 3'd6;
          rd = {1'b0, i[7:4]};
          im = {28'd0, i[3:0]};
        end
        default: begin
          fm = 3'd7;
          im = {{24{i[7]}}, i[7:0]};
        end
      endcase
    end
    return {wide, fm, op, rd, ra, rb, im};
  endfunction

  logic [15:0] hb;
  logic        hb_v;
  logic        ofs;
  logic [66:0] ph;
  logic        ph_v;

  wire [15:0] lo = in_word[15:0];
  wire [15:0] hi = in_word[31:16];
  wire        adv = !out_valid || out_ready;

  logic        take, wide, fin, eat, hb_load, ofs_set;
  logic [31:0] ins;

  always_comb begin
    take = 1'b0; wide = 1'b0; fin = 1'b0; eat = 1'b0;
    hb_load = 1'b0; ofs_set = 1'b0; ins = '0;
    if (in_valid) begin
      if (hb_v) begin
        take = 1'b1; wide = 1'b1; ins = {hb, lo};
        fin = in_last && hi[14]; ofs_set = 1'b1;
      end else if (!ofs) begin
        if (lo[14]) begin
          take = 1'b1; wide = 1'b1; ins = {lo, hi};
          fin = in_last; eat = 1'b1;
        end else begin
          take = 1'b1; ins = {16'd0, lo};
          fin = in_last && hi[14]; ofs_set = 1'b1;
        end
      end else if (hi[14]) begin
        eat = 1'b1; hb_load = !in_last;
      end else begin
        take = 1'b1; ins = {16'd0, hi};
        fin = in_last; eat = 1'b1;
      end
    end
  end

  wire        fuse = wide ? ins[31] : ins[15];
  wire [66:0] dec  = decode(ins, wide);
  wire        hold = take && !ph_v && fuse && !fin;
  wire        emit = take && !hold;

  assign in_ready = adv && eat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb <= '0; hb_v <= 1'b0; ofs <= 1'b0;
      ph <= '0; ph_v <= 1'b0;
      out_valid <= 1'b0; out_pair <= 1'b0;
      out_head <= '0; out_tail <= '0;
    end else if (adv) begin
      if (eat) ofs <= 1'b0;
      else if (ofs_set) ofs <= 1'b1;
      if (hb_load) begin
        hb <= hi; hb_v <= 1'b1;
      end else if (take && hb_v) begin
        hb_v <= 1'b0;
      end
      if (hold) begin
        ph <= dec; ph_v <= 1'b1;
      end else if (take) begin
        ph_v <= 1'b0;
      end
      out_valid <= emit;
      if (emit) begin
        out_pair <= ph_v;
        out_head <= ph_v ? ph : dec;
        out_tail <= ph_v ? dec : '0;
      end
    end
  end

endmodule

// File: rtl/mixlen_fuse_decoder_chk.sv
module mixlen_fuse_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_pair,
  input logic [66:0] out_head,
  input logic [66:0] out_tail
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pair) && $stable(out_head) && $stable(out_tail));

  p_stall_no_intake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_tail_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_pair |-> out_tail == '0);

  p_len_matches_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_head[66] == (out_head[65:63] <= 3'd4));

  p_rrr_no_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head[65:63] == 3'd4 |-> out_head[31:0] == '0);

  p_short_narrow_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_head[66] |-> !out_head[46] && !out_head[41] && out_head[36:32] == '0 && out_head[62:54] == '0);

  p_ready_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

endmodule

bind mixlen_fuse_decoder mixlen_fuse_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
  .out_head(out_head), .out_tail(out_tail)
);

// File: tb/mixlen_fuse_decoder_bench.sv
module mixlen_fuse_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;
  localparam int NE = 14;

  // {in_last, word}
  localparam logic [32:0] WORDS [NW] = '{
    {1'b0, 32'h34564012}, {1'b0, 32'h1B7C03A5}, {1'b0, 32'h5ABCA9F0},
    {1'b0, 32'h2F80D7E9}, {1'b0, 32'hBEEFE01F}, {1'b0, 32'h1234603F},
    {1'b0, 32'h4567F123}, {1'b0, 32'h10458312}, {1'b1, 32'hB0FF0123},
    {1'b1, 32'h70008C11}, {1'b1, 32'h0001C000}, {1'b0, 32'h10450042}
  };

  // {pair, head_is32, head, tail_is32, tail}
  localparam logic [66:0] EXP [NE] = '{
    {1'b0, 1'b1, 32'h40123456, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h000003A5, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h00001B7C, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h0000A9F0, 1'b1, 32'h5ABCD7E9},
    {1'b0, 1'b0, 32'h00002F80, 1'b0, 32'h0},
    {1'b1, 1'b1, 32'hE01FBEEF, 1'b1, 32'h603F1234},
    {1'b1, 1'b1, 32'hF1234567, 1'b0, 32'h00008312},
    {1'b0, 1'b0, 32'h00001045, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h00000123, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h0000B0FF, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h00008C11, 1'b0, 32'h0},
    {1'b0, 1'b1, 32'hC0000001, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h00000042, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h00001045, 1'b0, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_pair;
  logic [66:0] out_head, out_tail;
  logic mon_on = 1'b0, rdy_tbl = 1'b1, rdy_dir = 1'b1;
  wire  out_ready = mon_on ? rdy_tbl : rdy_dir;

  int checks = 0, errors = 0, cyc = 0, got = 0;
  bit done = 1'b0;

  mixlen_fuse_decoder u_mixlen_fuse_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_pair(out_pair), .out_head(out_head),
    .out_tail(out_tail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected slot built field by field from R3, R4 and R5
  function automatic logic [66:0] slot(input logic [31:0] x, input logic big);
    logic [66:0] s;
    s = '0;
    s[66] = big;
    if (big) begin
      s[62:47] = {6'd0, x[30:21]};
      if (x[29:28] == 2'b11) begin
        s[65:63] = 3'd4; s[62:47] = x[30:15];
        s[46:42] = x[14:10]; s[41:37] = x[9:5]; s[36:32] = x[4:0];
      end else if (x[29:28] == 2'b10) begin
        s[46:42] = x[20:16];
        s[65:63] = x[21] ? 3'd3 : 3'd2;
        s[31:0]  = x[21] ? (32'(x[15:0]) << 16) : 32'(x[15:0]);
      end else if (x[29:28] == 2'b01) begin
        s[65:63] = 3'd1; s[46:42] = x[20:16]; s[41:37] = x[15:11];
        s[31:0] = 32'(signed'(x[10:0]));
      end else begin
        s[31:0] = 32'(signed'(x[20:0]));
      end
    end else begin
      s[62:47] = {9'd0, x[14:8]};
      if (x[13]) begin
        s[65:63] = 3'd7; s[31:0] = 32'(signed'(x[7:0]));
      end else if (x[12]) begin
        s[65:63] = 3'd6; s[46:42] = {1'b0, x[7:4]}; s[31:0] = {28'd0, x[3:0]};
      end else begin
        s[65:63] = 3'd5; s[46:42] = {1'b0, x[7:4]}; s[41:37] = {1'b0, x[3:0]};
      end
    end
    return s;
  endfunction

  function automatic string etag(input int k);
    case (k)
      0: return "R3";
      1, 2, 4: return "R4";
      3: return "R6 R7";
      5: return "R7 R3";
      6, 7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // Table monitor: back-pressure pattern, hold check, in-order compare
  logic [66:0] snap_h, snap_t;
  logic        snap_p, was_stall = 1'b0;
  always @(negedge clk) if (mon_on) begin
    rdy_tbl = (cyc % 4) != 2;
    if (was_stall)
      chk(out_valid && out_head == snap_h && out_tail == snap_t && out_pair == snap_p,
          "R10 hold", out_head, snap_h);
    was_stall = out_valid && !rdy_tbl;
    snap_h = out_head; snap_t = out_tail; snap_p = out_pair;
    if (out_valid && rdy_tbl) begin
      if (got < NE) begin
        chk(out_pair == EXP[got][66], {"R7 pair flag ", etag(got)}, 67'(out_pair), 67'(EXP[got][66]));
        chk(out_head == slot(EXP[got][64:33], EXP[got][65]), {"R2 R5 head ", etag(got)},
            out_head, slot(EXP[got][64:33], EXP[got][65]));
        chk(out_tail == (EXP[got][66] ? slot(EXP[got][31:0], EXP[got][32]) : 67'd0),
            {"R11 tail ", etag(got)}, out_tail,
            EXP[got][66] ? slot(EXP[got][31:0], EXP[got][32]) : 67'd0);
      end else begin
        chk(1'b0, "R9 extra output", out_head, 67'd0);
      end
      got++;
    end
  end

  task automatic send(input logic [31:0] w, input logic l);
    in_word = w; in_last = l; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", 67'(out_valid), 67'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1 idle after reset", 67'({out_valid, in_ready}), 67'd0);

    // Table walk
    mon_on = 1'b1;
    for (int k = 0; k < NW; k++) send(WORDS[k][31:0], WORDS[k][32]);
    while (got < NE) @(negedge clk);
    repeat (6) @(negedge clk);
    mon_on = 1'b0;
    chk(got == NE, "R9 output count", 67'(got), 67'(NE));

    // R12: one word in, output on the following cycle
    rdy_dir = 1'b1;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    in_word = 32'h34564012; in_last = 1'b0; in_valid = 1'b1; #1;
    chk(in_ready, "R12 in_ready same cycle", 67'(in_ready), 67'd1);
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid && out_head == slot(32'h40123456, 1'b1), "R12 next-cycle output",
        out_head, slot(32'h40123456, 1'b1));
    @(negedge clk);
    chk(!out_valid, "R12 drained", 67'(out_valid), 67'd0);

    // R7 held head never emitted alone; R1 reset drops it
    in_word = 32'h0001C000; in_valid = 1'b1; @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid, "R7 head held alone", 67'(out_valid), 67'd0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    in_word = 32'h10450042; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && !out_pair && out_head == slot(32'h42, 1'b0), "R1 stale head dropped",
        out_head, slot(32'h42, 1'b0));
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);

    // R10: stalled output blocks intake
    rdy_dir = 1'b0;
    in_word = 32'h34564012; in_valid = 1'b1; @(negedge clk);
    in_word = 32'h1B7C03A5; #1;
    chk(out_valid && !in_ready, "R10 no intake while stalled", 67'({out_valid, in_ready}), 67'b10);
    repeat (2) @(negedge clk); #1;
    chk(!in_ready && out_head == slot(32'h40123456, 1'b1), "R10 held under stall",
        out_head, slot(32'h40123456, 1'b1));
    rdy_dir = 1'b1;
    @(negedge clk);
    chk(out_valid && out_head == slot(32'h03A5, 1'b0), "R10 resumes in order",
        out_head, slot(32'h03A5, 1'b0));
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule